// File: doc/BRIEF.md
# Hamming (7,4) Codec with Selectable Decode Policy

This block pairs a single-error Hamming encoder with a checking decoder for a distance-3 code over 4-bit data. The encoder turns a nibble into a 7-bit protected word. The decoder takes a received 7-bit word and forms a 3-bit syndrome. When the syndrome is nonzero, it names the 1-based position of the bit that is suspected to be wrong.

A distance-3 code cannot both repair one flipped bit and flag two flipped bits. A policy input therefore picks the decoder's behaviour, and the system holds it steady. In the repair policy the decoder inverts the named bit and raises a "corrected" flag. In the detect policy it changes nothing, passes the raw data field through, and raises an "error" flag. The encoder path and the decoder path are independent, and each has its own valid strobe. Every output comes from a register one clock after the accepted input.

Top module: `hcodec_top`

## Requirements
- R1: While reset is low and at the first sample after it, every output is zero: both valids, the code word, the data, the syndrome and both flags.
- R2: Codeword position k (1..7) is carried on bit k-1 of a code vector. Data bit d1 is bit 0 of the nibble and d4 is bit 3. Data bits d1..d4 sit at positions 3, 5, 6 and 7. The check bits sit at positions 1, 2 and 4 with p1=d1^d2^d4, p2=d1^d3^d4 and p4=d2^d3^d4. The encoded word appears one clock edge after `enc_valid_i`.
- R3: `enc_valid_o` follows `enc_valid_i` one edge later. `enc_code_o` loads only when `enc_valid_i` is high and otherwise holds its value.
- R4: The syndrome is {s4,s2,s1}, with s1=r1^r3^r5^r7, s2=r2^r3^r6^r7 and s4=r4^r5^r6^r7. It is reported under both policies. For a single flip at position k it equals k.
- R5: A zero syndrome gives data equal to the received data field, with both flags low, under either policy.
- R6: With `policy_i`=0 (repair) and a nonzero syndrome, the bit at that position is inverted before the data is taken out, `dec_corrected_o`=1 and `dec_error_o`=0.
- R7: With `policy_i`=1 (detect) and a nonzero syndrome, `dec_error_o`=1, `dec_corrected_o`=0, and the data is the unmodified field at positions 3, 5, 6 and 7.
- R8: Under the repair policy, a two-bit error yields the syndrome a^b, where a and b are the flipped positions. The bit at position a^b is flipped, and `dec_corrected_o` is raised. The result is a miscorrection to the nearest code word.
- R9: When `dec_valid_i` is low, the next cycle shows `dec_valid_o` low, both flags low, and data and syndrome unchanged. The encoder and decoder paths run at the same time without disturbing each other.
- R10: `dec_corrected_o` and `dec_error_o` are never high together, and neither is high without `dec_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_valid_i | input | 1 | Encoder input strobe |
| enc_data_i | input | 4 | Nibble to encode |
| enc_valid_o | output | 1 | Encoded word valid |
| enc_code_o | output | 7 | Encoded word, position k on bit k-1 |
| dec_valid_i | input | 1 | Decoder input strobe |
| dec_code_i | input | 7 | Received word, position k on bit k-1 |
| policy_i | input | 1 | 0 = repair single errors, 1 = detect only |
| dec_valid_o | output | 1 | Decoder result valid |
| dec_data_o | output | 4 | Repaired or raw data nibble |
| dec_syndrome_o | output | 3 | Syndrome {s4,s2,s1} |
| dec_corrected_o | output | 1 | A bit was inverted (repair policy) |
| dec_error_o | output | 1 | Nonzero syndrome seen (detect policy) |

## Verification
The hardest case to reach is the miscorrection. Two flips whose positions XOR to a third position must make the decoder confidently invert an innocent bit and still report a clean repair. The stimulus reaches it by walking every pair of distinct positions over a known code word under the repair policy. The expected data is predicted by flipping position a^b in the bench's own model. The same pairs are then sent under the detect policy, which shows that the raw field comes through with the error flag set.

// File: rtl/hcodec_pkg.sv
// Shared sizes and helpers for the Hamming codec.
// Assumes a perfect Hamming code: CODE_W = 2**CHK_W - 1.
package hcodec_pkg;
    localparam int unsigned CHK_W  = 3;
    localparam int unsigned CODE_W = (1 << CHK_W) - 1;
    localparam int unsigned DATA_W = CODE_W - CHK_W;

    typedef enum logic {POL_REPAIR = 1'b0, POL_DETECT = 1'b1} policy_e;

    // Positions (1-based) whose index has bit j set form the group of check bit j.
    function automatic logic [CODE_W-1:0] group_mask(int unsigned j);
        logic [CODE_W-1:0] m;
        m = '0;
        for (int unsigned p = 1; p <= CODE_W; p++) begin
            if (((p >> j) & 1) != 0) m = m | (CODE_W'(1) << (p - 1));
        end
        return m;
    endfunction
endpackage

// File: rtl/hcodec_encoder.sv
// Combinational encoder: places data bits at non-power-of-two positions
// and fills each power-of-two position with the parity of its group.
// Assumes position k lives on bit k-1.
module hcodec_encoder
    import hcodec_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] placed;
    logic [CHK_W-1:0]  par;

    for (genvar p = 1; p <= CODE_W; p++) begin : g_pos
        if ((p & (p - 1)) == 0) begin : g_chk
            localparam int CI = $clog2(p);
            // check slot: empty while forming parities, filled from par
            assign placed[p-1] = 1'b0;
            assign code[p-1]   = par[CI];
        end else begin : g_dat
            localparam int DI = p - $clog2(p + 1) - 1;
            // data slot: carries the next data bit in order
            assign placed[p-1] = data[DI];
            assign code[p-1]   = data[DI];
        end
    end

    for (genvar j = 0; j < CHK_W; j++) begin : g_par
        localparam logic [CODE_W-1:0] GRP = group_mask(j);
        // parity over the data bits covered by check bit j
        assign par[j] = ^(placed & GRP);
    end
endmodule

// File: rtl/hcodec_syndrome.sv
// Combinational syndrome generator: each bit is the parity of one group
// of received positions, so a single flip at position k yields k.
module hcodec_syndrome
    import hcodec_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [CHK_W-1:0]  syn
);
    for (genvar j = 0; j < CHK_W; j++) begin : g_syn
        localparam logic [CODE_W-1:0] GRP = group_mask(j);
        // parity of group j including its own check bit
        assign syn[j] = ^(code & GRP);
    end
endmodule

// File: rtl/hcodec_repair.sv
// Combinational policy stage: in repair mode inverts the position named by
// a nonzero syndrome; in detect mode leaves the word alone and flags it.
// Then extracts the data field. Assumes syn comes from hcodec_syndrome.
module hcodec_repair
    import hcodec_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [CHK_W-1:0]  syn,
    input  policy_e           policy,
    output logic [DATA_W-1:0] data,
    output logic              corrected,
    output logic              error
);
    logic [CODE_W-1:0] flip;
    logic [CODE_W-1:0] fixed;
    logic              nz;
    logic              fix_en;

    for (genvar p = 1; p <= CODE_W; p++) begin : g_flip
        // one-hot select of the position named by the syndrome
        assign flip[p-1] = (syn == CHK_W'(p));
    end

    assign nz     = |syn;
    assign fix_en = nz && (policy == POL_REPAIR);

    // apply the inversion only when the policy allows repair
    always_comb begin
        fixed     = fix_en ? (code ^ flip) : code;
        corrected = fix_en;
        error     = nz && (policy == POL_DETECT);
    end

    for (genvar p = 1; p <= CODE_W; p++) begin : g_ext
        if ((p & (p - 1)) != 0) begin : g_dat
            localparam int DI = p - $clog2(p + 1) - 1;
            // pull data bit DI from its code position
            assign data[DI] = fixed[p-1];
        end
    end
endmodule

// File: rtl/hcodec_top.sv
// Hamming (7,4) codec with one register stage on both paths.
// Encoder and decoder are independent; policy_i is sampled with each
// decoder word. Synchronous active-low reset clears all outputs.
module hcodec_top
    import hcodec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_valid_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_valid_o,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic              dec_valid_i,
    input  logic [CODE_W-1:0] dec_code_i,
    input  logic              policy_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [CHK_W-1:0]  dec_syndrome_o,
    output logic              dec_corrected_o,
    output logic              dec_error_o
);
    logic [CODE_W-1:0] enc_code_d;
    logic [CHK_W-1:0]  syn_d;
    logic [DATA_W-1:0] data_d;
    logic              corr_d;
    logic              err_d;

    hcodec_encoder u_enc (.data(enc_data_i), .code(enc_code_d));
    hcodec_syndrome u_syn (.code(dec_code_i), .syn(syn_d));
    hcodec_repair u_rep (
        .code(dec_code_i), .syn(syn_d), .policy(policy_e'(policy_i)),
        .data(data_d), .corrected(corr_d), .error(err_d)
    );

    // encoder output stage: valid every cycle, word only on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_valid_o <= 1'b0;
            enc_code_o  <= '0;
        end else begin
            enc_valid_o <= enc_valid_i;
            if (enc_valid_i) enc_code_o <= enc_code_d;
        end
    end

    // decoder output stage: flags qualified by valid, data held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid_o     <= 1'b0;
            dec_data_o      <= '0;
            dec_syndrome_o  <= '0;
            dec_corrected_o <= 1'b0;
            dec_error_o     <= 1'b0;
        end else begin
            dec_valid_o     <= dec_valid_i;
            dec_corrected_o <= dec_valid_i && corr_d;
            dec_error_o     <= dec_valid_i && err_d;
            if (dec_valid_i) begin
                dec_data_o     <= data_d;
                dec_syndrome_o <= syn_d;
            end
        end
    end
endmodule

// File: rtl/hcodec_checker.sv
// Property checker for hcodec_top, attached by bind. Recomputes the
// syndrome as the XOR of the indices of all set bits.
module hcodec_checker
    import hcodec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              enc_valid_i,
    input logic [DATA_W-1:0] enc_data_i,
    input logic              enc_valid_o,
    input logic [CODE_W-1:0] enc_code_o,
    input logic              dec_valid_i,
    input logic [CODE_W-1:0] dec_code_i,
    input logic              policy_i,
    input logic              dec_valid_o,
    input logic [DATA_W-1:0] dec_data_o,
    input logic [CHK_W-1:0]  dec_syndrome_o,
    input logic              dec_corrected_o,
    input logic              dec_error_o
);
    function automatic logic [CHK_W-1:0] idx_xor(logic [CODE_W-1:0] c);
        logic [CHK_W-1:0] s;
        s = '0;
        for (int p = 0; p < CODE_W; p++) if (c[p]) s = s ^ CHK_W'(p + 1);
        return s;
    endfunction

    p_enc_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_o |-> idx_xor(enc_code_o) == '0);
    p_enc_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |=> {enc_code_o[6], enc_code_o[5], enc_code_o[4], enc_code_o[2]} == $past(enc_data_i));
    p_enc_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |=> enc_valid_o);
    p_enc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid_i |=> !enc_valid_o && $stable(enc_code_o));
    p_syndrome_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> dec_syndrome_o == $past(idx_xor(dec_code_i)));
    p_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && dec_syndrome_o == '0) |-> !dec_corrected_o && !dec_error_o);
    p_repair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && !policy_i) |=> (dec_corrected_o == (dec_syndrome_o != '0)) && !dec_error_o);
    p_detect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && policy_i) |=> (dec_error_o == (dec_syndrome_o != '0)) && !dec_corrected_o);
    p_dec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> !dec_valid_o && !dec_corrected_o && !dec_error_o
                         && $stable(dec_data_o) && $stable(dec_syndrome_o));
    p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_corrected_o && dec_error_o));
    p_flags_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_corrected_o || dec_error_o) |-> dec_valid_o);
endmodule

bind hcodec_top hcodec_checker u_chk (.*);

// File: tb/hcodec_top_test.sv
module hcodec_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enc_valid_i = 1'b0;
    logic [3:0] enc_data_i = '0;
    logic       enc_valid_o;
    logic [6:0] enc_code_o;
    logic       dec_valid_i = 1'b0;
    logic [6:0] dec_code_i = '0;
    logic       policy_i = 1'b0;
    logic       dec_valid_o;
    logic [3:0] dec_data_o;
    logic [2:0] dec_syndrome_o;
    logic       dec_corrected_o;
    logic       dec_error_o;

    int checks = 0;
    int fails  = 0;

    hcodec_top uut (.*);

    always #10 clk = ~clk;

    // reference model: syndrome is XOR of 1-based indices of set bits
    function automatic logic [2:0] m_syn(logic [6:0] c);
        logic [2:0] s = '0;
        for (int p = 0; p < 7; p++) if (c[p]) s = s ^ 3'(p + 1);
        return s;
    endfunction

    function automatic logic [6:0] m_enc(logic [3:0] d);
        logic [6:0] c = '0;
        logic [2:0] s;
        c[2] = d[0]; c[4] = d[1]; c[5] = d[2]; c[6] = d[3];
        s = m_syn(c);
        c[0] = s[0]; c[1] = s[1]; c[3] = s[2];
        return c;
    endfunction

    function automatic logic [3:0] m_field(logic [6:0] c);
        return {c[6], c[5], c[4], c[2]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // send one word to the decoder, sample the registered result
    task automatic dec_step(logic [6:0] c, logic pol);
        @(negedge clk);
        dec_valid_i = 1'b1; dec_code_i = c; policy_i = pol;
        @(negedge clk);
        dec_valid_i = 1'b0;
    endtask

    task automatic check_flags_r10();
        check("R10 exclusive", {31'd0, dec_corrected_o & dec_error_o}, 32'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 enc_valid", {31'd0, enc_valid_o}, 0);
        check("R1 enc_code", {25'd0, enc_code_o}, 0);
        check("R1 dec outs", {22'd0, dec_valid_o, dec_data_o, dec_syndrome_o,
                              dec_corrected_o, dec_error_o}, 0);
    endtask

    task automatic t_encode_all();
        for (int d = 0; d < 16; d++) begin
            @(negedge clk);
            enc_valid_i = 1'b1; enc_data_i = 4'(d);
            @(negedge clk);
            enc_valid_i = 1'b0;
            check("R2 code word", {25'd0, enc_code_o}, {25'd0, m_enc(4'(d))});
            check("R3 enc valid", {31'd0, enc_valid_o}, 1);
        end
        // spot value: d=4'b1011 (d1=1,d2=1,d3=0,d4=1) -> p1=1,p2=0,p4=0
        @(negedge clk);
        enc_valid_i = 1'b1; enc_data_i = 4'b1011;
        @(negedge clk);
        enc_valid_i = 1'b0;
        check("R2 fixed value", {25'd0, enc_code_o}, {25'd0, 7'b1010101});
    endtask

    task automatic t_clean();
        for (int pol = 0; pol < 2; pol++)
            for (int d = 0; d < 16; d++) begin
                dec_step(m_enc(4'(d)), pol[0]);
                check("R5 data", {28'd0, dec_data_o}, d);
                check("R5 syndrome", {29'd0, dec_syndrome_o}, 0);
                check("R5 flags", {30'd0, dec_corrected_o, dec_error_o}, 0);
            end
    endtask

    task automatic t_single();
        logic [3:0] pats [3] = '{4'h0, 4'h9, 4'hF};
        for (int pol = 0; pol < 2; pol++)
            foreach (pats[i])
                for (int k = 1; k <= 7; k++) begin
                    logic [6:0] c = m_enc(pats[i]) ^ (7'd1 << (k - 1));
                    dec_step(c, pol[0]);
                    check("R4 syndrome", {29'd0, dec_syndrome_o}, k);
                    check_flags_r10();
                    if (pol == 0) begin
                        check("R6 data", {28'd0, dec_data_o}, {28'd0, pats[i]});
                        check("R6 corrected", {30'd0, dec_corrected_o, dec_error_o}, 2);
                    end else begin
                        check("R7 raw data", {28'd0, dec_data_o}, {28'd0, m_field(c)});
                        check("R7 error", {30'd0, dec_corrected_o, dec_error_o}, 1);
                    end
                end
    endtask

    task automatic t_double();
        for (int a = 1; a <= 7; a++)
            for (int b = a + 1; b <= 7; b++) begin
                logic [6:0] c = m_enc(4'h6) ^ (7'd1 << (a - 1)) ^ (7'd1 << (b - 1));
                logic [2:0] s = 3'(a ^ b);
                dec_step(c, 1'b0);
                check("R8 syndrome", {29'd0, dec_syndrome_o}, {29'd0, s});
                check("R8 miscorrect data", {28'd0, dec_data_o},
                      {28'd0, m_field(c ^ (7'd1 << (s - 1)))});
                check("R8 corrected", {30'd0, dec_corrected_o, dec_error_o}, 2);
                dec_step(c, 1'b1);
                check("R7 double raw", {28'd0, dec_data_o}, {28'd0, m_field(c)});
                check("R7 double error", {30'd0, dec_corrected_o, dec_error_o}, 1);
            end
    endtask

    task automatic t_hold();
        // both paths loaded in the same cycle
        @(negedge clk);
        enc_valid_i = 1'b1; enc_data_i = 4'h5;
        dec_valid_i = 1'b1; dec_code_i = m_enc(4'hC) ^ 7'b0010000; policy_i = 1'b0;
        @(negedge clk);
        enc_valid_i = 1'b0; dec_valid_i = 1'b0;
        check("R9 concurrent enc", {25'd0, enc_code_o}, {25'd0, m_enc(4'h5)});
        check("R9 concurrent dec", {28'd0, dec_data_o}, 32'hC);
        // change inputs with strobes low
        enc_data_i = 4'hA; dec_code_i = 7'h7F; policy_i = 1'b1;
        @(negedge clk);
        check("R3 enc hold", {25'd0, enc_code_o}, {25'd0, m_enc(4'h5)});
        check("R3 enc valid low", {31'd0, enc_valid_o}, 0);
        check("R9 dec data hold", {28'd0, dec_data_o}, 32'hC);
        check("R9 syndrome hold", {29'd0, dec_syndrome_o}, 5);
        check("R9 dec idle", {29'd0, dec_valid_o, dec_corrected_o, dec_error_o}, 0);
    endtask

    initial begin
        t_reset();
        t_encode_all();
        t_clean();
        t_single();
        t_double();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule